// File: doc/BRIEF.md
# Idle Entry and Wake Controller

This block gates the CPU clock around a power-save instruction that selects Idle mode. When the instruction decoder raises a one-cycle power-save strobe, the block takes the CPU clock enable low. It spends exactly one cycle in an entry state and then holds the core stopped. The system clock and the peripheral clocks are never touched, so peripherals keep running while the core is idle. When the core is entered into idle, the block sends a single-cycle clear pulse to the watchdog counter.

The core wakes on a watchdog time-out, on a reset, or on any interrupt source whose individual enable bit is set. On wake, the clock enable is restored on the same edge that sees the wake condition. The block records why it woke in a two-bit cause code. A flag tells the core whether to resume in the interrupt handler or at the instruction that follows the power-save instruction. An interrupt or time-out that arrives together with the power-save strobe, or during the entry cycle, does not abort entry. It is held and produces a wake as soon as the block reaches the idle state.

Top module: `idle_wake_ctrl`

## Requirements
- R1: One edge after `pwrsav_req` is sampled high in the running state, `cpu_clk_en` goes low. It stays low through the single entry cycle and for as long as the block is idle.
- R2: `wdt_clr` is high for exactly one cycle. That cycle is the first one after the power-save request is accepted. At all other times it is low.
- R3: While idle, if any bit of `irq_req & irq_en` is high at an edge, `cpu_clk_en` returns high on that edge. On the same edge `wake_cause` becomes 2'b01 (interrupt) and `resume_isr` becomes 1.
- R4: An interrupt request whose enable bit is clear never causes a wake, however long it stays pending.
- R5: While idle, a `wdt_timeout` pulse sampled at an edge restores `cpu_clk_en` on that edge. It also sets `wake_cause` to 2'b10 (watchdog) and `resume_isr` to 0, so execution resumes at the next instruction.
- R6: When `rst` is sampled high, the block returns to the running state from any state. `cpu_clk_en` becomes 1, `wdt_clr` becomes 0, `wake_cause` becomes 2'b11 (reset) and `resume_isr` becomes 0.
- R7: An enabled interrupt that is present with the power-save strobe, or during the entry cycle, does not abort entry. `cpu_clk_en` stays low for exactly two cycles, and the wake then reports cause 2'b01 with `resume_isr` 1.
- R8: If a watchdog wake and an interrupt wake apply at the same edge, the watchdog wins: the cause is 2'b10 and `resume_isr` is 0. This holds whether the interrupt is live or was held from entry. Reset outranks both.
- R9: A power-save strobe has no effect while the block is entering or idle. Accepting a new request clears `wake_cause` to 2'b00 and `resume_isr` to 0.
- R10: `wake_cause` and `resume_isr` keep their values while the block is running, until the next accepted request or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; never gated by this block |
| rst | input | 1 | Synchronous active-high reset; also a wake source |
| pwrsav_req | input | 1 | One-cycle strobe from the decoder for an Idle power-save instruction |
| irq_req | input | N_IRQ | Per-source interrupt request flags |
| irq_en | input | N_IRQ | Per-source interrupt enable bits |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| cpu_clk_en | output | 1 | CPU clock enable; low while entering or idle |
| wdt_clr | output | 1 | One-cycle clear pulse to the watchdog counter on entry |
| wake_cause | output | 2 | 00 none, 01 interrupt, 10 watchdog, 11 reset |
| resume_isr | output | 1 | 1: resume in the interrupt handler; 0: resume at the next instruction |

## Verification
The hardest situation to reach from the ports is an event that lands inside the short entry window. There are two cases: one exactly on the power-save strobe and one on the single entry cycle. The held event must then cause a wake on the very next edge, not be lost and not abort entry. The bench steps the strobe and the interrupt or time-out inputs on chosen cycles relative to the strobe. It checks that the enable stays low for exactly two cycles and that the cause follows the watchdog-over-interrupt ranking. A sweep of interrupt arrival delays after entry also checks that the wake happens on the edge that samples the request.

// File: rtl/idle_pkg.sv
package idle_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_IDLE  = 2'd2
    } idle_state_e;

    typedef enum logic [1:0] {
        WC_NONE = 2'b00,
        WC_IRQ  = 2'b01,
        WC_WDT  = 2'b10,
        WC_RST  = 2'b11
    } wake_cause_e;

    typedef struct packed {
        logic irq;
        logic wdt;
    } wake_evt_t;

    // Ranking between the clocked wake sources: watchdog before interrupt.
    function automatic wake_cause_e rank_cause(input wake_evt_t ev);
        if (ev.wdt)      return WC_WDT;
        else if (ev.irq) return WC_IRQ;
        else             return WC_NONE;
    endfunction

endpackage

// File: rtl/idle_irq_mask.sv
module idle_irq_mask #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             irq_hit
);
    logic [N_IRQ-1:0] gated;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_src
        assign gated[i] = irq_req[i] & irq_en[i];
    end

    assign irq_hit = |gated;
endmodule

// File: rtl/idle_cause_enc.sv
module idle_cause_enc
    import idle_pkg::*;
(
    input  logic        in_idle,
    input  logic        irq_live,
    input  logic        irq_held,
    input  logic        wdt_live,
    input  logic        wdt_held,
    output logic        wake,
    output wake_cause_e cause
);
    wake_evt_t ev;

    always_comb begin
        ev.irq = in_idle & (irq_live | irq_held);
        ev.wdt = in_idle & (wdt_live | wdt_held);
        cause  = rank_cause(ev);
        wake   = (cause != WC_NONE);
    end
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import idle_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwrsav_req,
    input  logic        irq_hit,
    input  logic        wdt_timeout,
    input  logic        wake,
    input  wake_cause_e wake_cause_nxt,
    output idle_state_e state,
    output logic        held_irq,
    output logic        held_wdt,
    output logic        cpu_clk_en,
    output logic        wdt_clr,
    output wake_cause_e wake_cause,
    output logic        resume_isr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RUN;
            held_irq   <= 1'b0;
            held_wdt   <= 1'b0;
            cpu_clk_en <= 1'b1;
            wdt_clr    <= 1'b0;
            wake_cause <= WC_RST;
            resume_isr <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    wdt_clr <= 1'b0;
                    if (pwrsav_req) begin
                        state      <= ST_ENTER;
                        cpu_clk_en <= 1'b0;
                        wdt_clr    <= 1'b1;
                        wake_cause <= WC_NONE;
                        resume_isr <= 1'b0;
                        held_irq   <= irq_hit;
                        held_wdt   <= wdt_timeout;
                    end
                end
                ST_ENTER: begin
                    state    <= ST_IDLE;
                    wdt_clr  <= 1'b0;
                    held_irq <= held_irq | irq_hit;
                    held_wdt <= held_wdt | wdt_timeout;
                end
                ST_IDLE: begin
                    if (wake) begin
                        state      <= ST_RUN;
                        cpu_clk_en <= 1'b1;
                        wake_cause <= wake_cause_nxt;
                        resume_isr <= (wake_cause_nxt == WC_IRQ);
                        held_irq   <= 1'b0;
                        held_wdt   <= 1'b0;
                    end
                end
                default: begin
                    state      <= ST_RUN;
                    cpu_clk_en <= 1'b1;
                    wdt_clr    <= 1'b0;
                end
            endcase
        end
    end

    AST_GATE_OFF_OUTSIDE_RUN: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RUN) |-> !cpu_clk_en); // R1
    AST_ENTRY_CLEARS_WDT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pwrsav_req) |=> wdt_clr); // R2
    AST_CLR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |=> !wdt_clr); // R2
    AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ENTER) |=> (state == ST_IDLE)); // R7
    AST_QUIET_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !irq_hit && !held_irq && !wdt_timeout && !held_wdt)
        |=> (state == ST_IDLE && !cpu_clk_en)); // R4
    AST_WDT_OUTRANKS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && wdt_timeout) |=> (wake_cause == WC_WDT && !resume_isr)); // R8
    AST_RESET_TO_RUN: assert property (@(posedge clk)
        rst |=> (state == ST_RUN && cpu_clk_en && wake_cause == WC_RST)); // R6
    AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && pwrsav_req && !wake) |=> (state == ST_IDLE)); // R9
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
    import idle_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwrsav_req,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    output logic             cpu_clk_en,
    output logic             wdt_clr,
    output logic [1:0]       wake_cause,
    output logic             resume_isr
);
    idle_state_e state;
    wake_cause_e cause_nxt;
    wake_cause_e cause_q;
    logic        irq_hit;
    logic        held_irq;
    logic        held_wdt;
    logic        wake;

    idle_irq_mask #(.N_IRQ(N_IRQ)) u_mask (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .irq_hit (irq_hit)
    );

    idle_cause_enc u_enc (
        .in_idle  (state == ST_IDLE),
        .irq_live (irq_hit),
        .irq_held (held_irq),
        .wdt_live (wdt_timeout),
        .wdt_held (held_wdt),
        .wake     (wake),
        .cause    (cause_nxt)
    );

    idle_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .pwrsav_req     (pwrsav_req),
        .irq_hit        (irq_hit),
        .wdt_timeout    (wdt_timeout),
        .wake           (wake),
        .wake_cause_nxt (cause_nxt),
        .state          (state),
        .held_irq       (held_irq),
        .held_wdt       (held_wdt),
        .cpu_clk_en     (cpu_clk_en),
        .wdt_clr        (wdt_clr),
        .wake_cause     (cause_q),
        .resume_isr     (resume_isr)
    );

    assign wake_cause = cause_q;

    AST_ISR_ONLY_ON_IRQ: assert property (@(posedge clk) disable iff (rst)
        resume_isr |-> (wake_cause == 2'b01)); // R3
    AST_CAUSE_HELD_RUNNING: assert property (@(posedge clk) disable iff (rst)
        ($past(cpu_clk_en) && cpu_clk_en) |-> $stable(wake_cause)); // R10
endmodule

// File: tb/test_idle_wake_ctrl.sv
`timescale 1ns/1ps
module test_idle_wake_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pwrsav_req = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_en = '0;
    logic         wdt_timeout = 1'b0;
    logic         cpu_clk_en;
    logic         wdt_clr;
    logic [1:0]   wake_cause;
    logic         resume_isr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    idle_wake_ctrl #(.N_IRQ(N)) i_idle_wake_ctrl (
        .clk(clk), .rst(rst), .pwrsav_req(pwrsav_req), .irq_req(irq_req),
        .irq_en(irq_en), .wdt_timeout(wdt_timeout), .cpu_clk_en(cpu_clk_en),
        .wdt_clr(wdt_clr), .wake_cause(wake_cause), .resume_isr(resume_isr)
    );

    // Advance to 2 ns after the next rising edge; drive and sample there.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); rst = 1'b0;
    endtask

    // Strobe a request; check the entry cycle and the first idle cycle.
    task automatic enter();
        pwrsav_req = 1'b1; step(); pwrsav_req = 1'b0;
        chk("R1 en low in entry", cpu_clk_en, 0);
        chk("R2 clr pulse", wdt_clr, 1);
        chk("R9 cause cleared", wake_cause, 0);
        chk("R9 isr cleared", resume_isr, 0);
        step();
        chk("R1 en low idle", cpu_clk_en, 0);
        chk("R2 clr one cycle", wdt_clr, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R6 reset en", cpu_clk_en, 1);
        chk("R6 reset clr", wdt_clr, 0);
        chk("R6 reset cause", wake_cause, 3);
        chk("R6 reset isr", resume_isr, 0);
    endtask

    task automatic t_irq_wake();
        irq_en = 8'h10;
        enter();
        repeat (3) step();
        chk("R1 still idle", cpu_clk_en, 0);
        irq_req = 8'h10; step(); irq_req = '0;
        chk("R3 en back", cpu_clk_en, 1);
        chk("R3 cause irq", wake_cause, 1);
        chk("R3 isr", resume_isr, 1);
        repeat (4) step();
        chk("R10 cause kept", wake_cause, 1);
        chk("R10 isr kept", resume_isr, 1);
        irq_en = '0;
    endtask

    task automatic t_masked();
        irq_en = 8'h0F;
        enter();
        irq_req = 8'hF0;
        repeat (20) step();
        chk("R4 masked no wake", cpu_clk_en, 0);
        chk("R4 cause none", wake_cause, 0);
        irq_en = 8'h8F; step();
        chk("R4 enabled bit wakes", cpu_clk_en, 1);
        chk("R3 cause", wake_cause, 1);
        irq_req = '0; irq_en = '0;
    endtask

    task automatic t_wdt_wake();
        enter();
        step();
        wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
        chk("R5 en back", cpu_clk_en, 1);
        chk("R5 cause wdt", wake_cause, 2);
        chk("R5 next instr", resume_isr, 0);
    endtask

    task automatic t_coincident(input bit on_strobe);
        irq_en = 8'h01;
        if (on_strobe) irq_req = 8'h01;
        pwrsav_req = 1'b1; step(); pwrsav_req = 1'b0;
        chk("R7 entry not aborted", cpu_clk_en, 0);
        if (!on_strobe) irq_req = 8'h01;
        step(); irq_req = '0;
        chk("R7 idle reached", cpu_clk_en, 0);
        step();
        chk("R7 held wake", cpu_clk_en, 1);
        chk("R7 cause", wake_cause, 1);
        chk("R7 isr", resume_isr, 1);
        irq_en = '0;
    endtask

    task automatic t_priority(input bit held);
        irq_en = 8'h02;
        if (held) irq_req = 8'h02;
        enter();
        irq_req = 8'h02; wdt_timeout = 1'b1; step();
        irq_req = '0; wdt_timeout = 1'b0;
        chk("R8 en back", cpu_clk_en, 1);
        chk("R8 wdt over irq", wake_cause, 2);
        chk("R8 isr low", resume_isr, 0);
        irq_en = '0;
    endtask

    task automatic t_ignore_busy();
        enter();
        pwrsav_req = 1'b1; repeat (3) step(); pwrsav_req = 1'b0;
        chk("R9 no effect idle", cpu_clk_en, 0);
        chk("R9 no clr", wdt_clr, 0);
        wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
        chk("R9 woke", cpu_clk_en, 1);
        step();
        chk("R10 stays running", cpu_clk_en, 1);
    endtask

    task automatic t_reset_in_idle();
        irq_en = 8'h01; irq_req = 8'h00;
        enter();
        wdt_timeout = 1'b1; irq_req = 8'h01; rst = 1'b1; step();
        rst = 1'b0; wdt_timeout = 1'b0; irq_req = '0;
        chk("R6 en", cpu_clk_en, 1);
        chk("R6 cause rst over all", wake_cause, 3);
        chk("R6 isr", resume_isr, 0);
        irq_en = '0;
    endtask

    task automatic t_sweep();
        irq_en = 8'h40;
        for (int d = 0; d < 12; d++) begin
            enter();
            for (int k = 0; k < d; k++) step();
            chk("R4 gate held through wait", cpu_clk_en, 0);
            irq_req = 8'h40; step(); irq_req = '0;
            chk("R3 sweep wake", cpu_clk_en, 1);
            chk("R3 sweep cause", wake_cause, 1);
            for (int k = 0; k < (d % 3); k++) step();
        end
        irq_en = '0;
    endtask

    initial begin
        #(8.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset_state();
        t_irq_wake();
        t_masked();
        t_wdt_wake();
        t_coincident(1'b1);
        t_coincident(1'b0);
        t_priority(1'b0);
        t_priority(1'b1);
        t_ignore_busy();
        t_reset_in_idle();
        t_sweep();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule